// File: doc/BRIEF.md
# Leaky-Bucket Reference Activity Monitor

This block decides whether a reference clock has gone quiet. Once per observation window, a strobe arrives with a flag that says whether the reference showed no activity during that window. An internal fill counter rises on each quiet window and falls on each active window. The counter is bounded by a programmable bucket size. A registered alarm turns on when the fill reaches an upper level. It turns off only when the fill has drained down to a lower level, so a reference that flickers near one level does not make the alarm chatter.

The three limits (bucket size, upper level, lower level) are 6-bit registers on a byte-wide read/write port. The block checks every write against the two limits it does not touch. A write that would break the ordering bucket ≥ upper > lower is dropped without any indication, and the register keeps its old value.

Top module: `lb_activity_monitor`

## Requirements
- R1: After reset the bucket size reads 20, the upper (assert) level reads 15, the lower (de-assert) level reads 10, the fill is zero and `alarm` is low.
- R2: `cfg_addr` 0 selects the bucket size, 1 the assert level and 2 the de-assert level; address 3 reads as zero. Each value occupies `cfg_wdata`/`cfg_rdata` bits 5:0. Bits 7:6 read as zero and are ignored on write.
- R3: A write to the bucket size takes effect only if the new value is greater than or equal to the current assert level; otherwise the register is unchanged.
- R4: A write to the assert level takes effect only if the new value is strictly greater than the current de-assert level and no greater than the current bucket size.
- R5: A write to the de-assert level takes effect only if the new value is strictly less than the current assert level.
- R6: A clock edge with `chk_stb` and `ref_idle` both high raises the fill by one, saturating at the bucket size.
- R7: A clock edge with `chk_stb` high and `ref_idle` low lowers the fill by one, saturating at zero.
- R8: `alarm` goes high on the clock edge after the edge that brings the fill up to or above the assert level.
- R9: Once high, `alarm` stays high while the fill is above the de-assert level. It goes low on the clock edge after the fill reaches the de-assert level or below. While the fill is strictly between the two levels, `alarm` keeps its value.
- R10: When an accepted write lowers the bucket size below the current fill, the fill is clamped to the new size on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 2 | Register select for reads and writes |
| cfg_wr | input | 1 | Write enable, sampled on the rising clock edge |
| cfg_wdata | input | 8 | Write data; bits 5:0 carry the value |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| chk_stb | input | 1 | One-cycle pulse at the end of each observation window |
| ref_idle | input | 1 | High when the reference was inactive in the window |
| alarm | output | 1 | Registered activity alarm |

## Verification
The monitor's core is driven with runs of quiet and active windows of chosen lengths. A run that stops one window short of the assert level is followed by a single quiet window, which pins the exact trigger point. Drains that stop just above the de-assert level, and refills that stop between the two levels, separate true hysteresis from a single threshold. Runs that go well past the bucket size or below zero before turning back show whether the counter saturates or wraps, because the alarm then changes at a different window count. Register writes are tried at each ordering boundary (equal to and one past each neighbour), and the bucket is shrunk beneath a full fill to expose the clamp.

// File: rtl/lb_activity_monitor.sv
module lb_activity_monitor #(
  parameter int W        = 6,
  parameter int SIZE_RST = 20,
  parameter int ASRT_RST = 15,
  parameter int DEAS_RST = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_addr,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       chk_stb,
  input  logic       ref_idle,
  output logic       alarm
);

  logic [W-1:0] size_q, asrt_q, deas_q, fill_q, step, fill_n;

  wire [W-1:0] wv = cfg_wdata[W-1:0];
  wire unused_hi  = |cfg_wdata[7:W];

  wire wr_size = cfg_wr && cfg_addr == 2'd0 && wv >= asrt_q;
  wire wr_asrt = cfg_wr && cfg_addr == 2'd1 && wv > deas_q && wv <= size_q;
  wire wr_deas = cfg_wr && cfg_addr == 2'd2 && wv < asrt_q;

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {{(8-W){1'b0}}, size_q};
      2'd1:    cfg_rdata = {{(8-W){1'b0}}, asrt_q};
      2'd2:    cfg_rdata = {{(8-W){1'b0}}, deas_q};
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= W'(SIZE_RST);
      asrt_q <= W'(ASRT_RST);
      deas_q <= W'(DEAS_RST);
    end else begin
      if (wr_size) size_q <= wv;
      if (wr_asrt) asrt_q <= wv;
      if (wr_deas) deas_q <= wv;
    end
  end

  always_comb begin
    step = fill_q;
    if (chk_stb) begin
      if (ref_idle) begin
        if (fill_q < size_q) step = fill_q + 1'b1;
      end else if (fill_q != '0) begin
        step = fill_q - 1'b1;
      end
    end
    fill_n = (step > size_q) ? size_q : step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      alarm  <= 1'b0;
    end else begin
      fill_q <= fill_n;
      if (fill_q >= asrt_q)      alarm <= 1'b1;
      else if (fill_q <= deas_q) alarm <= 1'b0;
    end
  end

  AST_LIMIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    size_q >= asrt_q && asrt_q > deas_q);                                      // R3
  AST_SIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr == 2'd0 && wv < asrt_q |=> $stable(size_q));           // R3
  AST_ASRT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr == 2'd1 && (wv <= deas_q || wv > size_q) |=> $stable(asrt_q)); // R4
  AST_DEAS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr == 2'd2 && wv >= asrt_q |=> $stable(deas_q));          // R5
  AST_FILL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb && ref_idle && !cfg_wr && fill_q < size_q |=> fill_q == $past(fill_q) + 1'b1); // R6
  AST_FILL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb && !ref_idle && fill_q == '0 |=> fill_q == '0);                   // R7
  AST_ALARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q >= asrt_q |=> alarm);                                               // R8
  AST_ALARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= deas_q |=> !alarm);                                              // R9
  AST_FILL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fill_q <= $past(size_q));                                         // R10

endmodule

// File: tb/test_lb_activity_monitor.sv
module test_lb_activity_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic cfg_wr = 1'b0, chk_stb = 1'b0, ref_idle = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic alarm;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lb_activity_monitor i_lb_activity_monitor (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_stb(chk_stb),
    .ref_idle(ref_idle), .alarm(alarm));

  // entry: {req, op, addr, data/count, expected}; op 0 read, 1 write, 2 quiet windows, 3 active windows
  localparam int N = 35;
  localparam logic [23:0] VEC [N] = '{
    {4'd1, 2'd0, 2'd0, 8'd20, 8'd20},   // R1
    {4'd1, 2'd0, 2'd1, 8'd0,  8'd15},   // R1
    {4'd1, 2'd0, 2'd2, 8'd0,  8'd10},   // R1
    {4'd2, 2'd0, 2'd3, 8'd0,  8'd0},    // R2
    {4'd8, 2'd2, 2'd0, 8'd14, 8'd0},    // R8 one short
    {4'd8, 2'd2, 2'd0, 8'd1,  8'd1},    // R8 reaches 15
    {4'd9, 2'd3, 2'd0, 8'd4,  8'd1},    // R9 fill 11
    {4'd9, 2'd3, 2'd0, 8'd1,  8'd0},    // R9 fill 10
    {4'd9, 2'd2, 2'd0, 8'd4,  8'd0},    // R9 fill 14, hold low
    {4'd6, 2'd2, 2'd0, 8'd10, 8'd1},    // R6 saturate at 20
    {4'd6, 2'd3, 2'd0, 8'd5,  8'd1},    // R6 fill 15
    {4'd6, 2'd3, 2'd0, 8'd5,  8'd0},    // R6 fill 10
    {4'd7, 2'd3, 2'd0, 8'd15, 8'd0},    // R7 floor at 0
    {4'd7, 2'd2, 2'd0, 8'd15, 8'd1},    // R7 fill 15
    {4'd3, 2'd1, 2'd0, 8'd14, 8'd0},    // R3 below assert level
    {4'd3, 2'd0, 2'd0, 8'd0,  8'd20},   // R3
    {4'd2, 2'd1, 2'd0, 8'hD6, 8'd0},    // R2 upper bits set
    {4'd2, 2'd0, 2'd0, 8'd0,  8'd22},   // R2
    {4'd4, 2'd1, 2'd1, 8'd23, 8'd0},    // R4 above size
    {4'd4, 2'd0, 2'd1, 8'd0,  8'd15},   // R4
    {4'd4, 2'd1, 2'd1, 8'd10, 8'd0},    // R4 equal to lower level
    {4'd4, 2'd0, 2'd1, 8'd0,  8'd15},   // R4
    {4'd4, 2'd1, 2'd1, 8'd22, 8'd0},    // R4 equal to size
    {4'd4, 2'd0, 2'd1, 8'd0,  8'd22},   // R4
    {4'd5, 2'd1, 2'd2, 8'd22, 8'd0},    // R5 equal to assert level
    {4'd5, 2'd0, 2'd2, 8'd0,  8'd10},   // R5
    {4'd5, 2'd1, 2'd2, 8'd21, 8'd0},    // R5 one below
    {4'd5, 2'd0, 2'd2, 8'd0,  8'd21},   // R5
    {4'd5, 2'd1, 2'd2, 8'd10, 8'd0},    // R5
    {4'd4, 2'd1, 2'd1, 8'd15, 8'd0},    // R4
    {4'd3, 2'd1, 2'd0, 8'd20, 8'd0},    // R3
    {4'd3, 2'd0, 2'd0, 8'd0,  8'd20},   // R3
    {4'd10, 2'd2, 2'd0, 8'd5, 8'd1},    // R10 fill 20
    {4'd10, 2'd1, 2'd0, 8'd16, 8'd0},   // R10 shrink bucket
    {4'd10, 2'd3, 2'd0, 8'd6, 8'd0}     // R10 16 -> 10
  };

  task automatic check(input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic windows(input bit idle, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); chk_stb = 1'b1; ref_idle = idle;
    end
    @(negedge clk); chk_stb = 1'b0; ref_idle = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input int req, input logic [1:0] a, input int exp);
    @(negedge clk); cfg_addr = a; #1;
    check(req, int'(cfg_rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, int'(alarm), 0);                 // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      logic [3:0] rq; logic [1:0] op, ad; logic [7:0] dt, ex;
      {rq, op, ad, dt, ex} = VEC[i];
      case (op)
        2'd0: rd_check(int'(rq), ad, int'(ex));
        2'd1: wr(ad, dt);
        2'd2: begin windows(1'b1, int'(dt)); check(int'(rq), int'(alarm), int'(ex)); end
        default: begin windows(1'b0, int'(dt)); check(int'(rq), int'(alarm), int'(ex)); end
      endcase
    end
    // R1: reset mid-run restores defaults and clears fill and alarm
    windows(1'b1, 10);
    check(1, int'(alarm), 1);
    wr(2'd2, 8'd5);
    rd_check(5, 2'd2, 5);                     // R5 accepted
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_check(1, 2'd2, 10);
    rd_check(1, 2'd0, 20);
    check(1, int'(alarm), 0);
    windows(1'b1, 14);                        // R1 fill restarted at zero
    check(1, int'(alarm), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; failures++; $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule